// File: doc/BRIEF.md
# Interrupt Destination Matcher and Arbiter

This block resolves where an inter-processor interrupt command goes among a parameterised set of targets (two to sixteen). Each command carries the sender's index, a two-bit destination shorthand, a physical/logical mode bit, an eight-bit destination and a delivery mode. Each target presents its own physical ID, logical ID, logical addressing format and an enabled flag.

For fixed delivery the block reports every matching target in a bit mask. For lowest-priority delivery it reports exactly one target. That target is picked by a rotating search that starts just past the previously chosen target. The block holds that pointer as its only state.

The result is registered. It appears, with a one-cycle done pulse, on the clock edge after the command strobe. Acceptance at the targets and all register storage lie outside this block.

Top module: `ipi_route`

## Requirements
- R1: With shorthand 1, only the target whose index equals `sender_i` matches.
- R2: With shorthand 2, every target matches.
- R3: With shorthand 3, every target except the sender matches.
- R4: With shorthand 0 and `logical_i` low, a target matches when `dest_i` is 0xFF or equals that target's physical ID.
- R5: With shorthand 0, `logical_i` high and target format 0 (flat), a target matches when its logical ID AND `dest_i` is nonzero.
- R6: With shorthand 0, `logical_i` high and target format 1 (cluster), a target matches when bits 7:4 of its logical ID equal bits 7:4 of `dest_i` and bits 3:0 of the two share a set bit.
- R7: A target whose format is 2 or 3 never matches in logical mode.
- R8: `done_o` is high for exactly the cycle after a cycle with `cmd_valid_i` high. `mask_o` is updated at that edge and holds otherwise. Reset clears both.
- R9: With `lowest_i` low (fixed delivery), `mask_o` is the full match set, independent of `tgt_en_i`.
- R10: With `lowest_i` high, `mask_o` is one-hot. The block picks the first target that both matches and is enabled, searching from the previous choice plus one and wrapping. That index then becomes the new previous choice.
- R11: With `lowest_i` high and no matching target enabled, the lowest-indexed matching target is chosen and the previous choice is left unchanged.
- R12: With `lowest_i` high and no match at all, target 0 is chosen and the previous choice is left unchanged.
- R13: After reset the previous choice is N-1, so the first lowest-priority search begins at target 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cmd_valid_i | input | 1 | Command strobe |
| sender_i | input | IDX_W | Index of the sending target |
| shorthand_i | input | 2 | 0 dest field, 1 self, 2 all, 3 all but self |
| logical_i | input | 1 | 0 physical, 1 logical addressing |
| dest_i | input | 8 | Destination field |
| lowest_i | input | 1 | 0 fixed delivery, 1 lowest-priority delivery |
| tgt_id_i | input | 8*N_TGT | Physical ID per target, target i at bits 8i+7:8i |
| tgt_lid_i | input | 8*N_TGT | Logical ID per target |
| tgt_fmt_i | input | 2*N_TGT | Logical format per target: 0 flat, 1 cluster |
| tgt_en_i | input | N_TGT | Target enabled flags |
| done_o | output | 1 | Result valid pulse |
| mask_o | output | N_TGT | Selected targets |

## Verification
The bench aims at the wrap of the rotating search. A pointer that failed to wrap, or that started from the pointer itself rather than one past it, would repeat or skip a target. It also checks that the fallback paths leave the pointer alone: a design that advanced the pointer on a fallback would shift every later lowest-priority pick by one. The physical broadcast value, the cluster nibble comparison and the invalid format codes are each probed with destinations that would match under a plain equality or a plain AND. The bench also confirms that fixed delivery ignores the enabled flags, which a design sharing the lowest-priority filter would break.

// File: rtl/ipi_route_pkg.sv
package ipi_route_pkg;
  typedef enum logic [1:0] {
    SH_DEST    = 2'd0,
    SH_SELF    = 2'd1,
    SH_ALL     = 2'd2,
    SH_OTHERS  = 2'd3
  } shorthand_e;

  typedef enum logic [1:0] {
    FMT_FLAT    = 2'd0,
    FMT_CLUSTER = 2'd1
  } lfmt_e;

  localparam logic [7:0] PHYS_BCAST = 8'hFF;
endpackage

// File: rtl/ipi_dest_match.sv
module ipi_dest_match
  import ipi_route_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int SELF  = 0
) (
  input  logic [IDX_W-1:0] sender_i,
  input  logic [1:0]       shorthand_i,
  input  logic             logical_i,
  input  logic [7:0]       dest_i,
  input  logic [7:0]       id_i,
  input  logic [7:0]       lid_i,
  input  logic [1:0]       fmt_i,
  output logic             hit_o
);
  logic is_self;
  logic log_hit;

  assign is_self = (sender_i == IDX_W'(SELF));

  always_comb begin
    unique case (fmt_i)
      FMT_FLAT:    log_hit = |(lid_i & dest_i);
      FMT_CLUSTER: log_hit = (lid_i[7:4] == dest_i[7:4]) && |(lid_i[3:0] & dest_i[3:0]);
      default:     log_hit = 1'b0;
    endcase
  end

  always_comb begin
    unique case (shorthand_i)
      SH_DEST:   hit_o = logical_i ? log_hit : ((dest_i == PHYS_BCAST) || (dest_i == id_i));
      SH_SELF:   hit_o = is_self;
      SH_ALL:    hit_o = 1'b1;
      default:   hit_o = !is_self;
    endcase
  end
endmodule

// File: rtl/ipi_rr_pick.sv
module ipi_rr_pick #(
  parameter int N_TGT = 8,
  parameter int IDX_W = 3
) (
  input  logic [IDX_W-1:0] ptr_i,
  input  logic [N_TGT-1:0] match_i,
  input  logic [N_TGT-1:0] en_i,
  output logic [N_TGT-1:0] pick_o,
  output logic             upd_o,
  output logic [IDX_W-1:0] next_ptr_o
);
  logic [IDX_W-1:0] rr_sel;
  logic [IDX_W-1:0] fb_sel;
  logic             found;

  // rotating search, starting one past the last choice
  always_comb begin
    found  = 1'b0;
    rr_sel = '0;
    for (int k = 1; k <= N_TGT; k++) begin
      int j;
      j = int'(ptr_i) + k;
      if (j >= N_TGT) j = j - N_TGT;
      if (!found && match_i[j] && en_i[j]) begin
        found  = 1'b1;
        rr_sel = IDX_W'(j);
      end
    end
  end

  always_comb begin
    fb_sel = '0;
    for (int i = N_TGT - 1; i >= 0; i--) begin
      if (match_i[i]) fb_sel = IDX_W'(i);
    end
  end

  always_comb begin
    pick_o = '0;
    if (found)          pick_o[rr_sel] = 1'b1;
    else if (|match_i)  pick_o[fb_sel] = 1'b1;
    else                pick_o[0]      = 1'b1;
  end

  assign upd_o      = found;
  assign next_ptr_o = rr_sel;
endmodule

// File: rtl/ipi_route.sv
module ipi_route
  import ipi_route_pkg::*;
#(
  parameter int N_TGT = 8,
  localparam int IDX_W = (N_TGT > 1) ? $clog2(N_TGT) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_valid_i,
  input  logic [IDX_W-1:0]   sender_i,
  input  logic [1:0]         shorthand_i,
  input  logic               logical_i,
  input  logic [7:0]         dest_i,
  input  logic               lowest_i,
  input  logic [8*N_TGT-1:0] tgt_id_i,
  input  logic [8*N_TGT-1:0] tgt_lid_i,
  input  logic [2*N_TGT-1:0] tgt_fmt_i,
  input  logic [N_TGT-1:0]   tgt_en_i,
  output logic               done_o,
  output logic [N_TGT-1:0]   mask_o
);
  localparam logic [IDX_W-1:0] PTR_RST = IDX_W'(N_TGT - 1);

  logic [N_TGT-1:0] match;
  logic [N_TGT-1:0] pick;
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] ptr_nxt;
  logic             ptr_upd;

  for (genvar g = 0; g < N_TGT; g++) begin : g_tgt
    ipi_dest_match #(.IDX_W(IDX_W), .SELF(g)) u_match (
      .sender_i    (sender_i),
      .shorthand_i (shorthand_i),
      .logical_i   (logical_i),
      .dest_i      (dest_i),
      .id_i        (tgt_id_i[8*g +: 8]),
      .lid_i       (tgt_lid_i[8*g +: 8]),
      .fmt_i       (tgt_fmt_i[2*g +: 2]),
      .hit_o       (match[g])
    );
  end

  ipi_rr_pick #(.N_TGT(N_TGT), .IDX_W(IDX_W)) u_pick (
    .ptr_i      (ptr_q),
    .match_i    (match),
    .en_i       (tgt_en_i),
    .pick_o     (pick),
    .upd_o      (ptr_upd),
    .next_ptr_o (ptr_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o <= 1'b0;
      mask_o <= '0;
      ptr_q  <= PTR_RST;
    end else begin
      done_o <= cmd_valid_i;
      if (cmd_valid_i) begin
        mask_o <= lowest_i ? pick : match;
        if (lowest_i && ptr_upd) ptr_q <= ptr_nxt;
      end
    end
  end
endmodule

// File: rtl/ipi_route_chk.sv
module ipi_route_chk #(
  parameter int N_TGT = 8,
  parameter int IDX_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic [IDX_W-1:0] sender_i,
  input logic [1:0]       shorthand_i,
  input logic             lowest_i,
  input logic             done_o,
  input logic [N_TGT-1:0] mask_o
);
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> done_o);
  p_done_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> !done_o);
  p_mask_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_valid_i |=> $stable(mask_o));
  p_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && lowest_i) |=> ($countones(mask_o) == 1));
  p_self_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !lowest_i && shorthand_i == 2'd1) |=> (mask_o == (N_TGT'(1) << $past(sender_i))));
  p_all_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !lowest_i && shorthand_i == 2'd2) |=> (&mask_o));
  p_others_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && !lowest_i && shorthand_i == 2'd3) |=> !mask_o[$past(sender_i)]);
endmodule

bind ipi_route ipi_route_chk #(.N_TGT(N_TGT), .IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cmd_valid_i (cmd_valid_i),
  .sender_i    (sender_i),
  .shorthand_i (shorthand_i),
  .lowest_i    (lowest_i),
  .done_o      (done_o),
  .mask_o      (mask_o)
);

// File: tb/ipi_route_bench.sv
module ipi_route_bench;
  localparam int N = 8;
  localparam int IW = 3;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           cmd_valid = 1'b0;
  logic [IW-1:0]  sender = '0;
  logic [1:0]     shorthand = '0;
  logic           logical = 1'b0;
  logic [7:0]     dest = '0;
  logic           lowest = 1'b0;
  logic [8*N-1:0] tgt_id;
  logic [8*N-1:0] tgt_lid;
  logic [2*N-1:0] tgt_fmt;
  logic [N-1:0]   tgt_en;
  logic           done;
  logic [N-1:0]   mask;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  ipi_route #(.N_TGT(N)) u_ipi_route (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .sender_i(sender),
    .shorthand_i(shorthand), .logical_i(logical), .dest_i(dest), .lowest_i(lowest),
    .tgt_id_i(tgt_id), .tgt_lid_i(tgt_lid), .tgt_fmt_i(tgt_fmt), .tgt_en_i(tgt_en),
    .done_o(done), .mask_o(mask)
  );

  task automatic check(input string req, input logic [N-1:0] got, input logic [N-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%02h exp=%02h", req, got, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // drive at negedge, sample the registered result at the following negedge
  task automatic send(input logic [1:0] sh, input logic lg, input logic [7:0] d,
                      input logic lo, input logic [IW-1:0] snd, input string req,
                      input logic [N-1:0] exp);
    shorthand = sh; logical = lg; dest = d; lowest = lo; sender = snd;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    check({req, " done"}, N'(done), N'(1));
    check(req, mask, exp);
  endtask

  task automatic setup_default();
    for (int i = 0; i < N; i++) begin
      tgt_id[8*i +: 8]  = 8'h10 + 8'(i);
      tgt_lid[8*i +: 8] = 8'h01 << i;
      tgt_fmt[2*i +: 2] = 2'd0;
    end
    tgt_en = '1;
  endtask

  task automatic t_reset();
    check("R8 reset done", N'(done), '0);
    check("R8 reset mask", mask, '0);
  endtask

  task automatic t_physical();
    send(2'd0, 1'b0, 8'h13, 1'b0, 3'd0, "R4 id match", 8'h08);
    send(2'd0, 1'b0, 8'hFF, 1'b0, 3'd0, "R4 broadcast", 8'hFF);
    send(2'd0, 1'b0, 8'h55, 1'b0, 3'd0, "R4 no match", 8'h00);
  endtask

  task automatic t_shorthand();
    send(2'd1, 1'b0, 8'h00, 1'b0, 3'd5, "R1 self", 8'h20);
    send(2'd2, 1'b1, 8'h00, 1'b0, 3'd5, "R2 all", 8'hFF);
    send(2'd3, 1'b0, 8'h10, 1'b0, 3'd2, "R3 all but self", 8'hFB);
  endtask

  task automatic t_flat();
    send(2'd0, 1'b1, 8'h81, 1'b0, 3'd0, "R5 flat", 8'h81);
    send(2'd0, 1'b1, 8'h00, 1'b0, 3'd0, "R5 flat zero", 8'h00);
  endtask

  task automatic t_cluster();
    for (int i = 0; i < N; i++) begin
      tgt_fmt[2*i +: 2] = 2'd1;
      tgt_lid[8*i +: 8] = {(i < 4) ? 4'h1 : 4'h2, 4'h1 << (i % 4)};
    end
    send(2'd0, 1'b1, 8'h23, 1'b0, 3'd0, "R6 cluster 2", 8'h30);
    send(2'd0, 1'b1, 8'h13, 1'b0, 3'd0, "R6 cluster 1", 8'h03);
    send(2'd0, 1'b1, 8'h30, 1'b0, 3'd0, "R6 cluster miss", 8'h00);
    setup_default();
  endtask

  task automatic t_bad_fmt();
    for (int i = 0; i < N; i++) tgt_lid[8*i +: 8] = 8'hFF;
    tgt_fmt[2*3 +: 2] = 2'd2;
    tgt_fmt[2*5 +: 2] = 2'd3;
    send(2'd0, 1'b1, 8'h01, 1'b0, 3'd0, "R7 bad format", 8'hD7);
    setup_default();
  endtask

  task automatic t_fixed_en();
    tgt_en = '0;
    send(2'd0, 1'b0, 8'hFF, 1'b0, 3'd0, "R9 fixed ignores enable", 8'hFF);
    tgt_en = '1;
  endtask

  task automatic t_rotate();
    do_reset();
    send(2'd0, 1'b0, 8'hFF, 1'b1, 3'd0, "R13 first pick", 8'h01);
    send(2'd0, 1'b0, 8'hFF, 1'b1, 3'd0, "R10 rotate", 8'h02);
    send(2'd0, 1'b0, 8'hFF, 1'b1, 3'd0, "R10 rotate", 8'h04);
    tgt_en = 8'hAA;
    send(2'd0, 1'b0, 8'hFF, 1'b1, 3'd0, "R10 skip disabled", 8'h08);
    send(2'd0, 1'b0, 8'hFF, 1'b1, 3'd0, "R10 skip disabled", 8'h20);
    send(2'd0, 1'b0, 8'hFF, 1'b1, 3'd0, "R10 last", 8'h80);
    send(2'd0, 1'b0, 8'hFF, 1'b1, 3'd0, "R10 wrap", 8'h02);
    tgt_en = '1;
  endtask

  task automatic t_fallback();
    // pointer is 1 here
    tgt_en = '0;
    send(2'd0, 1'b1, 8'h30, 1'b1, 3'd0, "R11 lowest match", 8'h10);
    tgt_en = '1;
    send(2'd0, 1'b0, 8'hFF, 1'b1, 3'd0, "R11 pointer kept", 8'h04);
    send(2'd0, 1'b0, 8'h55, 1'b1, 3'd0, "R12 no match", 8'h01);
    send(2'd0, 1'b0, 8'hFF, 1'b1, 3'd0, "R12 pointer kept", 8'h08);
  endtask

  task automatic t_idle();
    @(negedge clk);
    check("R8 done single cycle", N'(done), '0);
    check("R8 mask held", mask, 8'h08);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 8);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    setup_default();
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_physical();
    t_shorthand();
    t_flat();
    t_cluster();
    t_bad_fmt();
    t_fixed_en();
    t_rotate();
    t_fallback();
    t_idle();
    finish_run();
  end
endmodule